// File: doc/BRIEF.md
# Serial Character Transmitter with Transmit Queue

This block is the sending half of an asynchronous serial port. A CPU-side write port puts characters into a four-entry queue. A framing state machine takes each character from the queue and sends it on a single serial line. The line idles high. Each frame starts with one low bit, then sends the data bits least significant bit first, then an optional parity bit, then one or two high stop bits.

Bit timing comes from an external rate-enable pulse. In direct mode each enable pulse ends one bit. In oversampled mode an internal 16-step divider turns the enable pulses into one bit tick per 16 pulses. When a character arrives at an idle transmitter in that mode, the divider is cleared so the start bit begins at once. Its length is then counted from that point. A status flag reports when the line has gone quiet with nothing left to send.

The state machine has five states. `ST_IDLE` holds the line high. `ST_START` drives the start bit. `ST_DATA` shifts out the data bits. `ST_PARITY` sends the parity bit. `ST_STOP` drives the stop bits. The transitions are:
- IDLE→START: the queue is non-empty. This happens on the next clock and clears the divider.
- START→DATA: on a bit tick.
- DATA→PARITY or DATA→STOP: on the tick that ends the last data bit.
- PARITY→STOP: on a tick.
- STOP→START: the last stop bit ends and the queue is non-empty. There is no gap between the two frames.
- STOP→IDLE: the last stop bit ends and the queue is empty.

Top module: `serial_tx_fifo`

## Requirements
- R1: After reset, `txd` is 1, `fifo_full` is 0 and `tx_empty` is 1.
- R2: A frame is sent in this order:
  - one 0 bit;
  - the data bits, least significant bit first, where `len_sel` = 0, 1, 2, 3 selects 5, 6, 7, 8 bits;
  - the parity bit, if `par_en` is 1;
  - the stop bits, each a 1.
- R3: With `par_odd` = 0, the parity bit makes the count of ones in the data bits plus parity even. With `par_odd` = 1, it makes that count odd.
- R4: `two_stop` = 0 sends one stop bit. `two_stop` = 1 sends two.
- R5: With `os16` = 0, each bit lasts until the next cycle with `rate_en` = 1. With `os16` = 1, each bit lasts 16 `rate_en` pulses.
- R6: With `os16` = 1, loading a character into an idle transmitter clears the divider. The start bit then lasts exactly the next 16 `rate_en` pulses.
- R7: When the last stop bit ends and the queue is empty, `txd` stays 1 until another character is loaded.
- R8: `tx_empty` becomes 1 when the last stop bit ends with the queue empty. It becomes 0 on the edge that accepts a write.
- R9: The queue holds 4 characters. `fifo_full` is 1 while it holds 4. A write while `fifo_full` is 1 is dropped.
- R10: If the queue is non-empty when the last stop bit ends, the next start bit begins on that same edge. No idle bit is inserted.
- R11: `len_sel`, `par_en`, `par_odd` and `two_stop` are sampled when a character is loaded. Changing them mid-frame has no effect on that frame.
- R12: When the transmitter is idle and the queue is non-empty, `txd` goes to 0 on the next clock edge, without waiting for `rate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_en | input | 1 | Bit-rate enable pulse |
| os16 | input | 1 | 1 = 16x oversampled mode, 0 = direct mode |
| len_sel | input | 2 | Data length code (0..3 → 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Character to queue |
| fifo_full | output | 1 | Queue holds 4 characters |
| tx_empty | output | 1 | Line quiet and nothing queued |
| txd | output | 1 | Serial output |

## Verification
The assertions check several rules on every cycle:
- `txd` is high whenever `tx_empty` is set.
- A non-empty queue seen in idle produces a low start bit on the next edge.
- The end of the stop bits leads straight to a new start bit when a character is waiting.
- `tx_empty` sets or clears on the correct edge.
- A full queue stays full when a write arrives without a pop.

Other behaviours need the bench's scenarios and its cycle-accurate reference model:
- bit order and parity values for each length;
- bit lengths of exactly 16 pulses and the divider realignment;
- dropped writes;
- immunity to format changes in the middle of a frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_queue.sv
module sertx_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             wr_accept
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign wr_accept = wr_en && !full;
    assign rd_data   = store[rd_ptr];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_accept) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({wr_accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_accept) begin
            store[wr_ptr] <= wr_data;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !pop) |=> (full && $stable(count)));

endmodule

// File: rtl/sertx_divider.sv
module sertx_divider #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_en,
    input  logic os16,
    input  logic restart,
    output logic bit_tick
);
    localparam int SW = $clog2(OVERSAMPLE);

    logic [SW-1:0] sub;

    assign bit_tick = os16 ? (rate_en && (sub == SW'(OVERSAMPLE - 1))) : rate_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0;
        end else if (restart) begin
            sub <= '0;
        end else if (rate_en) begin
            sub <= (sub == SW'(OVERSAMPLE - 1)) ? '0 : sub + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  frame_cfg_t       cfg,
    input  logic             fifo_empty,
    input  logic [WIDTH-1:0] fifo_data,
    input  logic             wr_accept,
    output logic             pop,
    output logic             restart,
    output logic             txd,
    output logic             tx_empty
);
    localparam int IW = $clog2(WIDTH);

    tx_state_e        state, state_n;
    frame_cfg_t       cfg_q;
    logic [WIDTH-1:0] shreg;
    logic [IW-1:0]    bit_idx;
    logic             stop_idx;
    logic             par_bit;
    logic             empty_q;

    logic             last_data;
    logic             last_stop;
    logic             frame_done;
    logic             load;
    logic [WIDTH-1:0] data_mask;
    logic             new_parity;

    assign last_data  = (bit_idx == IW'(WIDTH - 4 + int'(cfg_q.len_sel)));
    assign last_stop  = !cfg_q.two_stop || stop_idx;
    assign frame_done = (state == ST_STOP) && bit_tick && last_stop;
    assign load       = ((state == ST_IDLE) || frame_done) && !fifo_empty;
    assign data_mask  = {WIDTH{1'b1}} >> (2'd3 - cfg.len_sel);
    assign new_parity = (^(fifo_data & data_mask)) ^ cfg.par_odd;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (!fifo_empty) state_n = ST_START;
            ST_START:  if (bit_tick) state_n = ST_DATA;
            ST_DATA:   if (bit_tick && last_data)
                           state_n = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_tick) state_n = ST_STOP;
            ST_STOP:   if (frame_done)
                           state_n = fifo_empty ? ST_IDLE : ST_START;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            par_bit  <= 1'b0;
            empty_q  <= 1'b1;
        end else begin
            state <= state_n;
            if (load) begin
                cfg_q    <= cfg;
                shreg    <= fifo_data;
                bit_idx  <= '0;
                stop_idx <= 1'b0;
                par_bit  <= new_parity;
            end else if (bit_tick) begin
                if (state == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                end
                if (state == ST_STOP) begin
                    stop_idx <= 1'b1;
                end
            end
            if (wr_accept) begin
                empty_q <= 1'b0;
            end else if (frame_done && fifo_empty) begin
                empty_q <= 1'b1;
            end
        end
    end

    always_comb begin
        pop      = load;
        restart  = (state == ST_IDLE) && !fifo_empty;
        tx_empty = empty_q;
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    // R12
    load_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !fifo_empty) |=> (txd == 1'b0));

    // R10
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !fifo_empty) |=> (state == ST_START && txd == 1'b0));

    // R8
    empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && fifo_empty && !wr_accept) |=> tx_empty);

    // R8
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !tx_empty);

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

endmodule

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo
    import sertx_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int WIDTH      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_en,
    input  logic             os16,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             fifo_full,
    output logic             tx_empty,
    output logic             txd
);
    frame_cfg_t       cfg;
    logic             q_empty;
    logic             q_accept;
    logic             q_pop;
    logic [WIDTH-1:0] q_data;
    logic             restart;
    logic             bit_tick;

    assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    sertx_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (q_pop),
        .rd_data   (q_data),
        .empty     (q_empty),
        .full      (fifo_full),
        .wr_accept (q_accept)
    );

    sertx_divider #(.OVERSAMPLE(OVERSAMPLE)) i_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_en  (rate_en),
        .os16     (os16),
        .restart  (restart),
        .bit_tick (bit_tick)
    );

    sertx_framer #(.WIDTH(WIDTH)) i_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .cfg        (cfg),
        .fifo_empty (q_empty),
        .fifo_data  (q_data),
        .wr_accept  (q_accept),
        .pop        (q_pop),
        .restart    (restart),
        .txd        (txd),
        .tx_empty   (tx_empty)
    );

endmodule

// File: tb/test_serial_tx_fifo.sv
`timescale 1ns/1ps
module test_serial_tx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_en = 1'b0;
    logic       os16 = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full;
    logic       tx_empty;
    logic       txd;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    rate_period = 1;
    string tag = "R1";

    // reference model state
    int q[$];
    int bits[$];
    bit busy = 0;
    int sub = 0;
    bit m_empty = 1;

    always #2.5 clk = ~clk;

    serial_tx_fifo i_serial_tx_fifo (
        .clk(clk), .rst_n(rst_n), .rate_en(rate_en), .os16(os16),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .tx_empty(tx_empty), .txd(txd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic void build_frame(input int d);
        int n;
        int ones;
        n = int'(len_sel) + 5;
        ones = 0;
        bits.delete();
        bits.push_back(0);
        for (int i = 0; i < n; i++) begin
            bits.push_back((d >> i) & 1);
            ones += (d >> i) & 1;
        end
        if (par_en) bits.push_back((ones % 2) ^ int'(par_odd));
        bits.push_back(1);
        if (two_stop) bits.push_back(1);
    endfunction

    always @(posedge clk) begin
        bit bt;
        bit acc;
        bit rs;
        if (!rst_n) begin
            q.delete(); bits.delete(); busy = 0; sub = 0; m_empty = 1;
        end else begin
            bt  = os16 ? (rate_en && sub == 15) : rate_en;
            acc = wr_en && (q.size() < 4);
            rs  = 0;
            if (busy) begin
                if (bt) begin
                    void'(bits.pop_front());
                    if (bits.size() == 0) begin
                        if (q.size() > 0) begin
                            build_frame(q.pop_front());
                        end else begin
                            busy = 0;
                            if (!acc) m_empty = 1;
                        end
                    end
                end
            end else if (q.size() > 0) begin
                build_frame(q.pop_front());
                busy = 1;
                rs = 1;
            end
            if (rs) sub = 0;
            else if (rate_en) sub = (sub + 1) % 16;
            if (acc) begin
                q.push_back(int'(wr_data));
                m_empty = 0;
            end
        end
    end

    // per-cycle comparison and rate-enable drive, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cyc > 3) begin
            check({tag, " txd"}, int'(txd), busy ? bits[0] : 1);
            check({tag, " tx_empty"}, int'(tx_empty), int'(m_empty));
            check({tag, " fifo_full"}, int'(fifo_full), int'(q.size() == 4));
        end
        rate_en = (rate_period <= 1) ? 1'b1 : ((cyc % rate_period) == 0);
    end

    task automatic put(input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        int n;
        n = 0;
        while (!(m_empty && !busy && q.size() == 0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            errors++;
            $display("FAIL %s: watchdog actual busy expected idle", tag);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 fifo_full", int'(fifo_full), 0);
        check("R1 tx_empty", int'(tx_empty), 1);

        // R2 R5 R7 R8: 8N1 in direct mode
        tag = "R2 R5 R7 R8";
        rate_period = 3;
        put(8'hA5);
        wait_quiet();
        put(8'h3C);
        wait_quiet();

        // R3 R4: 5 bits even parity, two stop bits; 7 bits odd parity
        tag = "R3 R4";
        len_sel = 2'd0; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
        put(8'h17);
        wait_quiet();
        len_sel = 2'd2; par_odd = 1'b1; two_stop = 1'b0;
        put(8'h55);
        wait_quiet();
        len_sel = 2'd1; par_odd = 1'b0;
        put(8'h00);
        wait_quiet();

        // R9 R10: burst past capacity, back-to-back frames
        tag = "R9 R10";
        len_sel = 2'd3; par_en = 1'b0; two_stop = 1'b0; rate_period = 2;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            wr_en = 1'b1;
            wr_data = 8'(8'h10 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R9 full after burst", int'(fifo_full), 1);
        wait_quiet();

        // R6 R12: oversampled mode, load at idle realigns divider
        tag = "R6 R12";
        os16 = 1'b1; rate_period = 2;
        repeat (7) @(negedge clk);
        put(8'hC3);
        @(negedge clk);
        check("R12 start bit at once", int'(txd), 0);
        wait_quiet();
        repeat (5) @(negedge clk);
        rate_period = 1;
        put(8'h81);
        wait_quiet();

        // R11: format change during a frame
        tag = "R11";
        os16 = 1'b0; rate_period = 2;
        len_sel = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        put(8'hF0);
        repeat (5) @(negedge clk);
        len_sel = 2'd0; par_en = 1'b1; two_stop = 1'b1;
        wait_quiet();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule